// File: doc/BRIEF.md
# PCI Power-Management State Controller

This block follows the device power state of a bridge function and exposes that state through a small configuration-register window. A configuration master reads and writes 32-bit dwords, selected by a dword address and four byte enables. The block decodes only the dwords it owns: the command/status dword, the capability-pointer dword, and the two dwords of the power-management capability. Every other address reads as zero. The block drives the current device state, a secondary bus power level derived from that state, an interrupt gated by the state, and a PME request.

The controller has six states. D0U is D0-uninitialized and D0A is D0-active. D1, D2 and D3H (D3hot) are the low-power states software can request. D3C (D3cold) is the state entered while the bus reset line is held. The transitions are:

- **Global reset:** every state goes to D0U at once.
- **D0U to D0A:** taken one cycle after both the I/O decode enable and the memory decode enable are set.
- **Software requests:** a write to the power-state field moves the block from D0 to D1, D2 or D3H, from D1 to D2 or D3H, and from D2 to D3H.
- **Return from D1 or D2:** a request for D0 goes to D0A when both decode enables are set, and to D0U otherwise.
- **Return from D3H:** a request for D0 goes to D0U and clears both decode enables.
- **Bus reset:** holding the bus reset low sends every state to D3C. Releasing it moves D3C to D0U.

PME context (the enable and status bits) survives bus reset. Only global reset clears it.

Top module: `pwrmgmt_ctl`

## Requirements
- R1: A low `grst_n` immediately puts the state in D0U and clears both decode enables, PME enable and PME status. `dev_state` encodes the states as 0 = D0U, 1 = D0A, 2 = D1, 3 = D2, 4 = D3H, 5 = D3C.
- R2: In D0U the state becomes D0A on the clock after bit 0 (I/O enable) and bit 1 (memory enable) of the dword at byte offset 04h both read 1. With only one of them set, the state stays D0U.
- R3: A write with byte enable 0 set to the power-state field (bits 1:0 of offset A4h; 00 = D0, 01 = D1, 10 = D2, 11 = D3hot) takes effect on the next clock.
  - From D0U or D0A, the codes 01, 10 and 11 are accepted.
  - From D1, the codes 10 and 11 are accepted.
  - From D2, the code 11 is accepted.
  - From D1 or D2, code 00 goes to D0A when both enables are set, and to D0U otherwise.
  - All other requests are ignored.
- R4: In D3H, writing 00 to the power-state field moves to D0U and clears both decode enables.
- R5: While `bus_rst_n` is low the state goes to D3C on the next clock, from any state. In D3C, the first clock with `bus_rst_n` high moves to D0U. Both decode enables are cleared in D3C, but PME enable and PME status are kept.
- R6: The power-state field reads 00 in D0U and D0A, 01 in D1, 10 in D2 and 11 in D3H. In D3C every read returns 0 and every write is ignored.
- R7: The following read-only fields hold fixed values, and every unmapped dword reads 0:
  - Bit 20 of the dword at 04h (status bit 4) reads 1.
  - Byte 0 at 14h reads A0h.
  - At A0h, byte 0 reads 01h and byte 1 reads 00h.
  - Bits 31:16 at A0h read the `CAP_BITS` parameter.
- R8: `bus_state` is 0 in D0U and D0A, 1 in D1, 2 in D2, and 3 in D3H and D3C.
- R9: PME enable is bit 8 of A4h and PME status is bit 15 of A4h, both written through byte enable 1.
  - A `wake_evt` pulse sets status when enable is 1 and the state is not D0U.
  - Writing 1 to bit 15 clears status.
  - `pme_out` is status AND enable outside D0U, and 0 in D0U.
- R10: `irq_out` equals `irq_raw` in D0A and is 0 in every other state.
- R11: Writes to the read-only fields (offsets 14h and A0h, and the status half of 04h) leave their read values unchanged.
- R12: A register byte changes only when its byte enable is set.
  - A write to A4h with only byte enable 1 set leaves the power state unchanged.
  - A write to 04h with byte enable 0 clear leaves the decode enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| grst_n | input | 1 | Global reset, asynchronous, active low |
| bus_rst_n | input | 1 | Bus reset, sampled, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Dword address (byte offset divided by 4) |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr`, combinational |
| irq_raw | input | 1 | Interrupt request from the function |
| wake_evt | input | 1 | Wake event pulse |
| dev_state | output | 3 | Current device state (encoding in R1) |
| bus_state | output | 2 | Secondary bus power level B0 to B3 |
| irq_out | output | 1 | Gated interrupt |
| pme_out | output | 1 | PME request |

## Verification
The assertions assume that configuration writes arrive as single-cycle strobes whose byte enables and data are stable for that cycle. They also assume that `bus_rst_n` and `wake_evt` are synchronous to the clock, and that `grst_n` is the only asynchronous input. The stimulus drives every input two nanoseconds after a rising edge and never changes one inside a cycle. It also never sets a PME-status clear and a wake event in the same cycle, so the set-over-clear priority is never what decides a check.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [2:0] {
        ST_D0U = 3'd0,
        ST_D0A = 3'd1,
        ST_D1  = 3'd2,
        ST_D2  = 3'd3,
        ST_D3H = 3'd4,
        ST_D3C = 3'd5
    } pm_state_e;

    localparam logic [7:0] OFF_CMD  = 8'h04;
    localparam logic [7:0] OFF_CAPP = 8'h14;
    localparam logic [7:0] OFF_CAP  = 8'hA0;
    localparam logic [7:0] OFF_CSR  = 8'hA4;
    localparam logic [7:0] CAP_ID   = 8'h01;
    localparam int         STS_CAPL_BIT = 20;

    function automatic logic [1:0] ps_code(input pm_state_e s);
        case (s)
            ST_D1:   return 2'b01;
            ST_D2:   return 2'b10;
            ST_D3H:  return 2'b11;
            default: return 2'b00;
        endcase
    endfunction
endpackage

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      grst_n,
    input  logic      bus_rst_n,
    input  logic      cmd_io,
    input  logic      cmd_mem,
    input  logic      ps_wr,
    input  logic [1:0] ps_val,
    output pm_state_e state
);
    pm_state_e nxt;
    logic      both_en;

    assign both_en = cmd_io && cmd_mem;

    always_ff @(posedge clk or negedge grst_n) begin
        if (!grst_n) state <= ST_D0U;
        else         state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (!bus_rst_n) begin
            nxt = ST_D3C;
        end else begin
            unique case (state)
                ST_D0U: begin
                    if (both_en) nxt = ST_D0A;
                    else if (ps_wr && ps_val == 2'b01) nxt = ST_D1;
                    else if (ps_wr && ps_val == 2'b10) nxt = ST_D2;
                    else if (ps_wr && ps_val == 2'b11) nxt = ST_D3H;
                end
                ST_D0A: begin
                    if (ps_wr && ps_val == 2'b01) nxt = ST_D1;
                    else if (ps_wr && ps_val == 2'b10) nxt = ST_D2;
                    else if (ps_wr && ps_val == 2'b11) nxt = ST_D3H;
                end
                ST_D1: begin
                    if (ps_wr && ps_val == 2'b00) nxt = both_en ? ST_D0A : ST_D0U;
                    else if (ps_wr && ps_val == 2'b10) nxt = ST_D2;
                    else if (ps_wr && ps_val == 2'b11) nxt = ST_D3H;
                end
                ST_D2: begin
                    if (ps_wr && ps_val == 2'b00) nxt = both_en ? ST_D0A : ST_D0U;
                    else if (ps_wr && ps_val == 2'b11) nxt = ST_D3H;
                end
                ST_D3H: begin
                    if (ps_wr && ps_val == 2'b00) nxt = ST_D0U;
                end
                ST_D3C: nxt = ST_D0U;
                default: nxt = ST_D0U;
            endcase
        end
    end

    AST_UNINIT_EXIT: assert property (@(posedge clk) disable iff (!grst_n)
        (state == ST_D0U && cmd_io && cmd_mem && bus_rst_n) |=> (state == ST_D0A)); // R2
    AST_BUSRST_COLD: assert property (@(posedge clk) disable iff (!grst_n)
        (!bus_rst_n) |=> (state == ST_D3C)); // R5
    AST_COLD_EXIT: assert property (@(posedge clk) disable iff (!grst_n)
        (state == ST_D3C && bus_rst_n) |=> (state == ST_D0U)); // R5
    AST_D3H_TO_D0U: assert property (@(posedge clk) disable iff (!grst_n)
        (state == ST_D3H && bus_rst_n && ps_wr && ps_val == 2'b00) |=> (state == ST_D0U)); // R4
endmodule

// File: rtl/pm_cfg_regs.sv
module pm_cfg_regs
    import pmc_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter int          DATA_W   = 32,
    parameter logic [15:0] CAP_BITS = 16'hFE03
) (
    input  logic              clk,
    input  logic              grst_n,
    input  logic              bus_rst_n,
    input  pm_state_e         state,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W/8-1:0] cfg_be,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              wake_evt,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              ps_wr,
    output logic [1:0]        ps_val,
    output logic              cmd_io,
    output logic              cmd_mem,
    output logic              pme_en,
    output logic              pme_sts
);
    localparam logic [ADDR_W-1:0] DW_CMD  = ADDR_W'(OFF_CMD  >> 2);
    localparam logic [ADDR_W-1:0] DW_CAPP = ADDR_W'(OFF_CAPP >> 2);
    localparam logic [ADDR_W-1:0] DW_CAP  = ADDR_W'(OFF_CAP  >> 2);
    localparam logic [ADDR_W-1:0] DW_CSR  = ADDR_W'(OFF_CSR  >> 2);

    logic acc, wr_ok, hit_cmd, hit_csr, d3h_wake, sts_set, sts_clr;

    assign acc      = (state != ST_D3C) && bus_rst_n;
    assign wr_ok    = acc && cfg_wr;
    assign hit_cmd  = wr_ok && (cfg_addr == DW_CMD);
    assign hit_csr  = wr_ok && (cfg_addr == DW_CSR);
    assign ps_wr    = hit_csr && cfg_be[0];
    assign ps_val   = cfg_wdata[1:0];
    assign d3h_wake = (state == ST_D3H) && ps_wr && (ps_val == 2'b00);
    assign sts_set  = wake_evt && pme_en && (state != ST_D0U);
    assign sts_clr  = hit_csr && cfg_be[1] && cfg_wdata[15];

    always_ff @(posedge clk or negedge grst_n) begin
        if (!grst_n) begin
            cmd_io  <= 1'b0;
            cmd_mem <= 1'b0;
        end else if (state == ST_D3C || d3h_wake) begin
            cmd_io  <= 1'b0;
            cmd_mem <= 1'b0;
        end else if (hit_cmd && cfg_be[0]) begin
            cmd_io  <= cfg_wdata[0];
            cmd_mem <= cfg_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge grst_n) begin
        if (!grst_n) begin
            pme_en  <= 1'b0;
            pme_sts <= 1'b0;
        end else begin
            if (hit_csr && cfg_be[1]) pme_en <= cfg_wdata[8];
            if (sts_set)      pme_sts <= 1'b1;
            else if (sts_clr) pme_sts <= 1'b0;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (state != ST_D3C) begin
            if (cfg_addr == DW_CMD) begin
                cfg_rdata[0]            = cmd_io;
                cfg_rdata[1]            = cmd_mem;
                cfg_rdata[STS_CAPL_BIT] = 1'b1;
            end else if (cfg_addr == DW_CAPP) begin
                cfg_rdata[7:0] = OFF_CAP;
            end else if (cfg_addr == DW_CAP) begin
                cfg_rdata[31:0] = {CAP_BITS, 8'h00, CAP_ID};
            end else if (cfg_addr == DW_CSR) begin
                cfg_rdata[1:0] = ps_code(state);
                cfg_rdata[8]   = pme_en;
                cfg_rdata[15]  = pme_sts;
            end
        end
    end

    AST_CMD_CLEAR_COLD: assert property (@(posedge clk) disable iff (!grst_n)
        (state == ST_D3C) |=> (!cmd_io && !cmd_mem)); // R5
    AST_PME_W1C: assert property (@(posedge clk) disable iff (!grst_n)
        (sts_clr && !wake_evt) |=> !pme_sts); // R9
    AST_NO_SET_UNINIT: assert property (@(posedge clk) disable iff (!grst_n)
        (state == ST_D0U && !pme_sts && !bus_rst_n == 1'b0) |=> !pme_sts || $past(state) != ST_D0U); // R9
endmodule

// File: rtl/pwrmgmt_ctl.sv
module pwrmgmt_ctl
    import pmc_pkg::*;
#(
    parameter int          ADDR_W   = 6,
    parameter logic [15:0] CAP_BITS = 16'hFE03
) (
    input  logic              clk,
    input  logic              grst_n,
    input  logic              bus_rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              irq_raw,
    input  logic              wake_evt,
    output logic [2:0]        dev_state,
    output logic [1:0]        bus_state,
    output logic              irq_out,
    output logic              pme_out
);
    pm_state_e state;
    logic      ps_wr, cmd_io, cmd_mem, pme_en, pme_sts;
    logic [1:0] ps_val;

    pm_state_fsm u_fsm (
        .clk(clk), .grst_n(grst_n), .bus_rst_n(bus_rst_n),
        .cmd_io(cmd_io), .cmd_mem(cmd_mem),
        .ps_wr(ps_wr), .ps_val(ps_val), .state(state)
    );

    pm_cfg_regs #(.ADDR_W(ADDR_W), .DATA_W(32), .CAP_BITS(CAP_BITS)) u_regs (
        .clk(clk), .grst_n(grst_n), .bus_rst_n(bus_rst_n), .state(state),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .wake_evt(wake_evt), .cfg_rdata(cfg_rdata),
        .ps_wr(ps_wr), .ps_val(ps_val), .cmd_io(cmd_io), .cmd_mem(cmd_mem),
        .pme_en(pme_en), .pme_sts(pme_sts)
    );

    always_comb begin
        dev_state = state;
        bus_state = 2'd0;
        irq_out   = 1'b0;
        pme_out   = pme_sts && pme_en;
        unique case (state)
            ST_D0U: pme_out = 1'b0;
            ST_D0A: irq_out = irq_raw;
            ST_D1:  bus_state = 2'd1;
            ST_D2:  bus_state = 2'd2;
            ST_D3H: bus_state = 2'd3;
            ST_D3C: bus_state = 2'd3;
            default: bus_state = 2'd3;
        endcase
    end

    AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!grst_n)
        irq_out |-> irq_raw); // R10
endmodule

// File: tb/sim_pwrmgmt_ctl.sv
`timescale 1ns/1ps
module sim_pwrmgmt_ctl;
    logic        clk = 1'b0;
    logic        grst_n = 1'b0;
    logic        bus_rst_n = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic        irq_raw = 1'b0;
    logic        wake_evt = 1'b0;
    logic [31:0] cfg_rdata;
    logic [2:0]  dev_state;
    logic [1:0]  bus_state;
    logic        irq_out, pme_out;

    int total = 0;
    int bad   = 0;
    bit started = 0;
    bit done = 0;

    // reference model state
    int ms = 0;
    int mio = 0, mmem = 0, men = 0, msts = 0;

    always #5 clk = ~clk;

    pwrmgmt_ctl #(.ADDR_W(6), .CAP_BITS(16'hFE03)) u0 (
        .clk(clk), .grst_n(grst_n), .bus_rst_n(bus_rst_n), .cfg_wr(cfg_wr),
        .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_raw(irq_raw), .wake_evt(wake_evt),
        .dev_state(dev_state), .bus_state(bus_state),
        .irq_out(irq_out), .pme_out(pme_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk or negedge grst_n) begin
        if (!grst_n) begin
            ms = 0; mio = 0; mmem = 0; men = 0; msts = 0;
        end else begin
            int ns, nio, nmem, nen, nsts, pv;
            bit acc, wr, csrw, psw;
            acc  = (ms != 5) && bus_rst_n;
            wr   = acc && cfg_wr;
            csrw = wr && (cfg_addr == 6'd41);
            psw  = csrw && cfg_be[0];
            pv   = int'(cfg_wdata[1:0]);
            ns = ms; nio = mio; nmem = mmem; nen = men; nsts = msts;
            if (!bus_rst_n) ns = 5;
            else case (ms)
                0: if (mio && mmem) ns = 1; else if (psw && pv != 0) ns = pv + 1;
                1: if (psw && pv != 0) ns = pv + 1;
                2: if (psw) begin
                       if (pv == 0) ns = (mio && mmem) ? 1 : 0;
                       else if (pv >= 2) ns = pv + 1;
                   end
                3: if (psw) begin
                       if (pv == 0) ns = (mio && mmem) ? 1 : 0;
                       else if (pv == 3) ns = 4;
                   end
                4: if (psw && pv == 0) ns = 0;
                default: ns = 0;
            endcase
            if (ms == 5 || (ms == 4 && psw && pv == 0)) begin nio = 0; nmem = 0; end
            else if (wr && cfg_addr == 6'd1 && cfg_be[0]) begin
                nio = cfg_wdata[0]; nmem = cfg_wdata[1];
            end
            if (csrw && cfg_be[1]) nen = cfg_wdata[8];
            if (wake_evt && men && ms != 0) nsts = 1;
            else if (csrw && cfg_be[1] && cfg_wdata[15]) nsts = 0;
            ms = ns; mio = nio; mmem = nmem; men = nen; msts = nsts;
            started = 1;
        end
    end

    function automatic logic [31:0] exp_rd();
        logic [31:0] r = '0;
        if (ms == 5) return r;
        case (cfg_addr)
            6'd1:  begin r[0] = mio[0]; r[1] = mmem[0]; r[20] = 1'b1; end
            6'd5:  r[7:0] = 8'hA0;
            6'd40: r = 32'hFE03_0001;
            6'd41: begin
                r[1:0] = (ms == 2) ? 2'b01 : (ms == 3) ? 2'b10 : (ms == 4) ? 2'b11 : 2'b00;
                r[8] = men[0]; r[15] = msts[0];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    always @(negedge clk) begin
        if (started && !done) begin
            chk("R3 dev_state", 32'(dev_state), 32'(ms));
            chk("R8 bus_state", 32'(bus_state),
                32'((ms == 2) ? 1 : (ms == 3) ? 2 : (ms >= 4) ? 3 : 0));
            chk("R10 irq_out", 32'(irq_out), 32'(irq_raw && ms == 1));
            chk("R9 pme_out", 32'(pme_out), 32'(msts != 0 && men != 0 && ms != 0));
            chk("R6 cfg_rdata", cfg_rdata, exp_rd());
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
    endtask

    task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
        @(posedge clk); #2;
        cfg_wr = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
        @(posedge clk); #2;
        cfg_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a);
        cfg_addr = a; #1;
    endtask

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        step(2); grst_n = 1'b1; step(1);
        chk("R1 reset state", 32'(dev_state), 32'd0);
        rd(6'd1);  chk("R1 cmd cleared", cfg_rdata & 32'h3, 32'h0);
        chk("R7 status cap bit", 32'(cfg_rdata[20]), 32'd1);
        rd(6'd5);  chk("R7 cap pointer", cfg_rdata, 32'h0000_00A0);
        rd(6'd40); chk("R7 cap header", cfg_rdata, 32'hFE03_0001);
        rd(6'd33); chk("R7 unmapped", cfg_rdata, 32'h0);

        wr(6'd1, 4'b0001, 32'h1); step(2);
        chk("R2 only io stays uninit", 32'(dev_state), 32'd0);
        wr(6'd1, 4'b1110, 32'h3); step(1);
        rd(6'd1); chk("R12 cmd be0 clear", cfg_rdata & 32'h3, 32'h1);
        wr(6'd1, 4'b0001, 32'h3); step(1);
        chk("R2 both enables", 32'(dev_state), 32'd1);

        irq_raw = 1'b1; #1; chk("R10 irq in D0A", 32'(irq_out), 32'd1);
        step(1); irq_raw = 1'b0;

        wr(6'd5, 4'hF, 32'hFFFF_FFFF); wr(6'd40, 4'hF, 32'hFFFF_FFFF);
        wr(6'd1, 4'b1100, 32'hFFFF_0000);
        rd(6'd5);  chk("R11 cap pointer ro", cfg_rdata, 32'h0000_00A0);
        rd(6'd40); chk("R11 cap header ro", cfg_rdata, 32'hFE03_0001);
        rd(6'd1);  chk("R11 status ro", cfg_rdata, 32'h0010_0003);

        wr(6'd41, 4'b0010, 32'h0000_0103);
        chk("R12 ps needs be0", 32'(dev_state), 32'd1);
        rd(6'd41); chk("R9 pme enable set", 32'(cfg_rdata[8]), 32'd1);
        wake_evt = 1'b1; step(1); wake_evt = 1'b0; #1;
        chk("R9 pme raised", 32'(pme_out), 32'd1);
        wr(6'd41, 4'b0010, 32'h0000_8100); #1;
        chk("R9 w1c clears", 32'(pme_out), 32'd0);

        wr(6'd41, 4'b0001, 32'h1);
        chk("R3 to D1", 32'(dev_state), 32'd2);
        irq_raw = 1'b1; #1; chk("R10 irq blocked D1", 32'(irq_out), 32'd0);
        irq_raw = 1'b0;
        wr(6'd41, 4'b0001, 32'h2); chk("R3 D1 to D2", 32'(dev_state), 32'd3);
        wr(6'd41, 4'b0001, 32'h1); chk("R3 D2 to D1 ignored", 32'(dev_state), 32'd3);
        wr(6'd41, 4'b0001, 32'h0); chk("R3 D2 to D0A", 32'(dev_state), 32'd1);
        wr(6'd41, 4'b0001, 32'h3); chk("R3 to D3hot", 32'(dev_state), 32'd4);
        rd(6'd41); chk("R6 ps code D3hot", 32'(cfg_rdata[1:0]), 32'd3);
        wr(6'd41, 4'b0001, 32'h0); chk("R4 D3hot to uninit", 32'(dev_state), 32'd0);
        rd(6'd1); chk("R4 enables cleared", cfg_rdata & 32'h3, 32'h0);

        wake_evt = 1'b1; step(1); wake_evt = 1'b0; #1;
        chk("R9 no pme in uninit", 32'(pme_out), 32'd0);

        wr(6'd1, 4'b0001, 32'h3); step(1);
        bus_rst_n = 1'b0; step(2);
        chk("R5 bus reset cold", 32'(dev_state), 32'd5);
        rd(6'd1); chk("R6 cold reads zero", cfg_rdata, 32'h0);
        wake_evt = 1'b1; step(1); wake_evt = 1'b0;
        bus_rst_n = 1'b1; step(1);
        chk("R5 release to uninit", 32'(dev_state), 32'd0);
        chk("R9 pme gated uninit", 32'(pme_out), 32'd0);
        rd(6'd41); chk("R5 pme context kept", cfg_rdata & 32'h8100, 32'h8100);
        wr(6'd1, 4'b0001, 32'h3); step(1);
        chk("R9 pme after init", 32'(pme_out), 32'd1);

        grst_n = 1'b0; #1;
        chk("R1 async global reset", 32'(dev_state), 32'd0);
        step(2); grst_n = 1'b1; step(2);
        rd(6'd41); chk("R1 pme cleared", cfg_rdata, 32'h0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule